// File: doc/BRIEF.md
# Fetch Group Extractor with Branch Delay Slots

The block sits between a buffered instruction line and the decode stage of a wide pipeline. Each cycle it takes the line held for the current fetch address, picks out a group of up to `FETCH_W` consecutive 32-bit instructions starting at that address, and presents them in parallel slots. Each slot carries:

- a valid bit,
- the instruction word,
- its address,
- the address of the instruction that executes after it,
- a sequence number.

It keeps the fetch address, the next address and the address after that for the following cycle.

Control-flow information comes from an external predictor that describes each slot position:

- whether the slot holds a control instruction,
- whether that branch is predicted taken,
- whether a not-taken branch annuls its delay slot,
- the predicted target.

A predicted-taken branch does not end the group. The instruction in its delay slot is still fetched, and only after that slot has been emitted does fetch move to the saved target. This still holds when the delay slot falls into the next cycle's group. A squash input moves fetch to a new address. It cancels a pending delay slot when the squash is at or before the branch that created it.

Top module: `fetch_group_unit`

## Requirements
- R1: After reset, fetchPc is RESET_PC (0), fetchNextPc is fetchPc+4, fetchNextNextPc is fetchPc+8, the base sequence number (slotSeq slot 0) is 0, and no slot is valid while lineValid is low.
- R2: While lineValid and squashValid are both low, no slot is valid, and the fetch addresses and sequence numbers keep their values at the next edge, whatever the predictor inputs are.
- R3: The first instruction word is selected by fetchPc bits [5:2]; word w of the line is lineData[32w+31:32w]. Slot k holds word (start+k), its address is the aligned fetchPc plus 4k, and its sequence number is the base sequence number plus k.
- R4: Valid slots are contiguous from slot 0. With no control flow, the group ends at the line end or after FETCH_W slots. At the next edge fetchPc becomes the address after the last slot, next PCs follow at +4 and +8, and the base sequence number grows by the slot count.
- R5: A non-control slot, or a control slot predicted not taken without annulment, reports a next address of its own address plus 4.
- R6: A slot predicted taken (brIsCtrl and brTaken of its position) reports next address plus 4. The following slot is its delay slot: it is emitted, its predictor flags are ignored, it reports the saved target as next address, and the group ends there. At the next edge fetchPc becomes the target, with +4 and +8 after it.
- R7: When a predicted-taken branch is the last slot of a group, the delay slot becomes slot 0 of the next valid group, which reports the saved target and redirects fetch to it.
- R8: A control slot predicted not taken with brAnnul set reports its own address plus 8 as next address. The group ends at that slot, and fetchPc becomes that slot's address plus 8.
- R9: While squashValid is high no slot is valid, whether or not lineValid is high. At the next edge fetchPc becomes squashPc, fetchNextPc squashPc+4 and fetchNextNextPc squashPc+8.
- R10: A squash whose squashSeq is at or below the sequence number of the last predicted-taken branch cancels a pending delay slot and its target. A squash with a larger number leaves the pending slot in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineValid | input | 1 | Buffered line holds the block of fetchPc |
| lineData | input | 512 | Instruction line, word w in bits [32w+31:32w] |
| squashValid | input | 1 | Redirect fetch this cycle |
| squashPc | input | 32 | New fetch address on squash |
| squashSeq | input | 16 | Sequence number of the squashing instruction |
| brIsCtrl | input | 4 | Slot position holds a control instruction |
| brTaken | input | 4 | Control slot predicted taken |
| brAnnul | input | 4 | Not-taken control slot annuls its delay slot |
| brTarget | input | 128 | Predicted target per slot position, 32 bits each |
| slotValid | output | 4 | Slot carries an instruction |
| slotInst | output | 128 | Instruction word per slot |
| slotPc | output | 128 | Address per slot |
| slotNextPc | output | 128 | Address executed after each slot |
| slotSeq | output | 64 | Sequence number per slot, 16 bits each |
| fetchPc | output | 32 | Current fetch address |
| fetchNextPc | output | 32 | Address after fetchPc |
| fetchNextNextPc | output | 32 | Address two instructions after fetchPc |

## Verification
The slot outputs depend combinationally on the current inputs and the registered state, so they are due in the same cycle the inputs are driven. The bench compares them in the middle of the low clock phase, after the inputs have settled and before the edge. The fetch addresses, the pending delay slot and the base sequence number change at the next rising edge. The bench compares those one nanosecond after that edge, against a model that was advanced with the same inputs. Because of this, a delay slot carried across two groups (R7) or a squash that cancels it (R10) shows up as a wrong slot-0 next address or a wrong fetchPc in the cycle after the one that caused it.

// File: rtl/fgu_pkg.sv
`timescale 1ns/1ps
package fgu_pkg;

  // width of the per-cycle slot count carried in the strobes
  localparam int CNT_W = 8;

  // where a slot's successor lies
  typedef enum logic [1:0] {
    NEXT_SEQ    = 2'd0,
    NEXT_SKIP   = 2'd1,
    NEXT_TARGET = 2'd2
  } nextKind_t;

  // control -> datapath strobes for the address registers
  typedef struct packed {
    logic             squash;
    logic             advance;
    logic             redirect;
    logic             skip;
    logic [CNT_W-1:0] count;
  } pcStrobes_t;

endpackage

// File: rtl/fgu_datapath.sv
`timescale 1ns/1ps
module fgu_datapath
  import fgu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INST_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int FETCH_W    = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int INST_BYTES = INST_W / 8,
  localparam int LINE_WORDS = LINE_BYTES / INST_BYTES,
  localparam int IDX_W      = $clog2(LINE_WORDS),
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int SH_W       = $clog2(INST_BYTES)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  pcStrobes_t                        strobes,
  input  logic [ADDR_W-1:0]                 squashPc,
  input  logic [ADDR_W-1:0]                 redirectTarget,
  input  logic [LINE_BYTES*8-1:0]           lineData,
  input  nextKind_t [FETCH_W-1:0]           slotKind,
  output logic [IDX_W-1:0]                  startIdx,
  output logic [FETCH_W-1:0][INST_W-1:0]    slotInst,
  output logic [FETCH_W-1:0][ADDR_W-1:0]    slotPc,
  output logic [FETCH_W-1:0][ADDR_W-1:0]    slotNextPc,
  output logic [ADDR_W-1:0]                 fetchPc,
  output logic [ADDR_W-1:0]                 fetchNextPc,
  output logic [ADDR_W-1:0]                 fetchNextNextPc
);

  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(INST_BYTES);
  localparam logic [IDX_W:0]    WORDS_LIM = (IDX_W+1)'(LINE_WORDS);

  logic [ADDR_W-1:0] pcQ, npcQ, nnpcQ;
  logic [ADDR_W-1:0] basePc;
  logic [ADDR_W-1:0] pcD;

  // instruction-aligned fetch address and start word inside the line
  assign basePc   = {pcQ[ADDR_W-1:SH_W], SH_W'(0)};
  assign startIdx = pcQ[OFF_W-1:SH_W];

  generate
    for (genvar k = 0; k < FETCH_W; k++) begin : g_slot
      localparam logic [IDX_W:0] K_OFF = (IDX_W+1)'(k);
      logic [IDX_W:0] wordIdx;

      assign wordIdx     = {1'b0, startIdx} + K_OFF;
      assign slotInst[k] = (wordIdx < WORDS_LIM)
                         ? lineData[INST_W*int'(wordIdx[IDX_W-1:0]) +: INST_W]
                         : '0;
      assign slotPc[k]   = basePc + ADDR_W'(k * INST_BYTES);

      always_comb begin
        case (slotKind[k])
          NEXT_SKIP:   slotNextPc[k] = slotPc[k] + STEP + STEP;
          NEXT_TARGET: slotNextPc[k] = redirectTarget;
          default:     slotNextPc[k] = slotPc[k] + STEP;
        endcase
      end
    end
  endgenerate

  // fetch address for the following cycle
  always_comb begin
    pcD = pcQ;
    if (strobes.squash) begin
      pcD = squashPc;
    end else if (strobes.advance) begin
      if (strobes.redirect) begin
        pcD = redirectTarget;
      end else begin
        pcD = basePc + (ADDR_W'(strobes.count) << SH_W) + (strobes.skip ? STEP : '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= RESET_PC;
      npcQ  <= RESET_PC + STEP;
      nnpcQ <= RESET_PC + STEP + STEP;
    end else if (strobes.squash || strobes.advance) begin
      pcQ   <= pcD;
      npcQ  <= pcD + STEP;
      nnpcQ <= pcD + STEP + STEP;
    end
  end

  assign fetchPc         = pcQ;
  assign fetchNextPc     = npcQ;
  assign fetchNextNextPc = nnpcQ;

endmodule

// File: rtl/fgu_control.sv
`timescale 1ns/1ps
module fgu_control
  import fgu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FETCH_W    = 4,
  parameter int LINE_WORDS = 16,
  parameter int SEQ_W      = 16,
  localparam int IDX_W     = $clog2(LINE_WORDS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           lineValid,
  input  logic                           squashValid,
  input  logic [SEQ_W-1:0]               squashSeq,
  input  logic [IDX_W-1:0]               startIdx,
  input  logic [FETCH_W-1:0]             brIsCtrl,
  input  logic [FETCH_W-1:0]             brTaken,
  input  logic [FETCH_W-1:0]             brAnnul,
  input  logic [FETCH_W-1:0][ADDR_W-1:0] brTarget,
  output pcStrobes_t                     strobes,
  output logic [FETCH_W-1:0]             slotValid,
  output nextKind_t [FETCH_W-1:0]        slotKind,
  output logic [ADDR_W-1:0]              redirectTarget,
  output logic [FETCH_W-1:0][SEQ_W-1:0]  slotSeq
);

  // registered delay-slot and sequence state
  logic              pendQ;
  logic [ADDR_W-1:0] targetQ;
  logic [SEQ_W-1:0]  brSeqQ;
  logic              brSeqValidQ;
  logic [SEQ_W-1:0]  seqQ;

  // results of this cycle's walk over the slots
  logic              run;
  logic              pendN;
  logic [ADDR_W-1:0] targetN;
  logic              targetReady;
  logic              skipHit;
  logic              takenSeen;
  logic [SEQ_W-1:0]  brSeqN;
  logic [CNT_W-1:0]  cnt;
  logic              squashHitsBranch;

  always_comb begin
    run         = lineValid && !squashValid;
    pendN       = pendQ;
    targetN     = targetQ;
    targetReady = 1'b0;
    skipHit     = 1'b0;
    takenSeen   = 1'b0;
    brSeqN      = brSeqQ;
    cnt         = '0;
    slotValid   = '0;
    for (int k = 0; k < FETCH_W; k++) begin
      slotKind[k] = NEXT_SEQ;
      if (run && (int'(startIdx) + k < LINE_WORDS)) begin
        slotValid[k] = 1'b1;
        cnt          = CNT_W'(k + 1);
        if (pendN) begin
          // delay slot: its own prediction is ignored, then go to target
          pendN       = 1'b0;
          targetReady = 1'b1;
          slotKind[k] = NEXT_TARGET;
          run         = 1'b0;
        end else if (brIsCtrl[k]) begin
          if (brTaken[k]) begin
            pendN     = 1'b1;
            targetN   = brTarget[k];
            takenSeen = 1'b1;
            brSeqN    = seqQ + SEQ_W'(k);
          end else if (brAnnul[k]) begin
            skipHit     = 1'b1;
            slotKind[k] = NEXT_SKIP;
            run         = 1'b0;
          end
        end
      end
    end
  end

  assign squashHitsBranch = squashValid && brSeqValidQ && (squashSeq <= brSeqQ);

  always_comb begin
    strobes.squash   = squashValid;
    strobes.advance  = lineValid && !squashValid;
    strobes.redirect = targetReady;
    strobes.skip     = skipHit;
    strobes.count    = cnt;
  end

  assign redirectTarget = targetN;

  generate
    for (genvar k = 0; k < FETCH_W; k++) begin : g_seq
      assign slotSeq[k] = seqQ + SEQ_W'(k);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ       <= 1'b0;
      targetQ     <= '0;
      brSeqQ      <= '0;
      brSeqValidQ <= 1'b0;
      seqQ        <= '0;
    end else if (squashValid) begin
      if (squashHitsBranch) begin
        pendQ       <= 1'b0;
        targetQ     <= '0;
        brSeqValidQ <= 1'b0;
      end
    end else if (lineValid) begin
      pendQ   <= pendN;
      targetQ <= targetN;
      seqQ    <= seqQ + SEQ_W'(cnt);
      if (takenSeen) begin
        brSeqQ      <= brSeqN;
        brSeqValidQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fetch_group_unit.sv
`timescale 1ns/1ps
module fetch_group_unit
  import fgu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INST_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int FETCH_W    = 4,
  parameter int SEQ_W      = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int LINE_WORDS = LINE_BYTES / (INST_W / 8),
  localparam int IDX_W      = $clog2(LINE_WORDS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        lineValid,
  input  logic [LINE_BYTES*8-1:0]     lineData,
  input  logic                        squashValid,
  input  logic [ADDR_W-1:0]           squashPc,
  input  logic [SEQ_W-1:0]            squashSeq,
  input  logic [FETCH_W-1:0]          brIsCtrl,
  input  logic [FETCH_W-1:0]          brTaken,
  input  logic [FETCH_W-1:0]          brAnnul,
  input  logic [FETCH_W*ADDR_W-1:0]   brTarget,
  output logic [FETCH_W-1:0]          slotValid,
  output logic [FETCH_W*INST_W-1:0]   slotInst,
  output logic [FETCH_W*ADDR_W-1:0]   slotPc,
  output logic [FETCH_W*ADDR_W-1:0]   slotNextPc,
  output logic [FETCH_W*SEQ_W-1:0]    slotSeq,
  output logic [ADDR_W-1:0]           fetchPc,
  output logic [ADDR_W-1:0]           fetchNextPc,
  output logic [ADDR_W-1:0]           fetchNextNextPc
);

  pcStrobes_t                     strobes;
  logic [ADDR_W-1:0]              redirectTarget;
  nextKind_t [FETCH_W-1:0]        slotKind;
  logic [IDX_W-1:0]               startIdx;
  logic [FETCH_W-1:0][ADDR_W-1:0] brTargetArr;
  logic [FETCH_W-1:0][INST_W-1:0] slotInstArr;
  logic [FETCH_W-1:0][ADDR_W-1:0] slotPcArr;
  logic [FETCH_W-1:0][ADDR_W-1:0] slotNextPcArr;
  logic [FETCH_W-1:0][SEQ_W-1:0]  slotSeqArr;

  assign brTargetArr = brTarget;
  assign slotInst    = slotInstArr;
  assign slotPc      = slotPcArr;
  assign slotNextPc  = slotNextPcArr;
  assign slotSeq     = slotSeqArr;

  fgu_control #(
    .ADDR_W    (ADDR_W),
    .FETCH_W   (FETCH_W),
    .LINE_WORDS(LINE_WORDS),
    .SEQ_W     (SEQ_W)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .lineValid     (lineValid),
    .squashValid   (squashValid),
    .squashSeq     (squashSeq),
    .startIdx      (startIdx),
    .brIsCtrl      (brIsCtrl),
    .brTaken       (brTaken),
    .brAnnul       (brAnnul),
    .brTarget      (brTargetArr),
    .strobes       (strobes),
    .slotValid     (slotValid),
    .slotKind      (slotKind),
    .redirectTarget(redirectTarget),
    .slotSeq       (slotSeqArr)
  );

  fgu_datapath #(
    .ADDR_W    (ADDR_W),
    .INST_W    (INST_W),
    .LINE_BYTES(LINE_BYTES),
    .FETCH_W   (FETCH_W),
    .RESET_PC  (RESET_PC)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .squashPc       (squashPc),
    .redirectTarget (redirectTarget),
    .lineData       (lineData),
    .slotKind       (slotKind),
    .startIdx       (startIdx),
    .slotInst       (slotInstArr),
    .slotPc         (slotPcArr),
    .slotNextPc     (slotNextPcArr),
    .fetchPc        (fetchPc),
    .fetchNextPc    (fetchNextPc),
    .fetchNextNextPc(fetchNextNextPc)
  );

endmodule

// File: rtl/fgu_checker.sv
`timescale 1ns/1ps
module fgu_checker #(
  parameter int ADDR_W  = 32,
  parameter int FETCH_W = 4,
  parameter int SEQ_W   = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     lineValid,
  input logic                     squashValid,
  input logic [ADDR_W-1:0]        squashPc,
  input logic [FETCH_W-1:0]       slotValid,
  input logic [FETCH_W*SEQ_W-1:0] slotSeq,
  input logic [ADDR_W-1:0]        fetchPc,
  input logic [ADDR_W-1:0]        fetchNextPc
);

  // R2
  idle_no_slots_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineValid |-> (slotValid == '0));

  // R2
  idle_state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lineValid && !squashValid) |=> ($stable(fetchPc) && $stable(slotSeq)));

  // R3
  first_slot_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && !squashValid) |-> slotValid[0]);

  // R4
  slots_contiguous_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((slotValid + 1'b1) & slotValid) == '0));

  // R9
  squash_no_slots_chk: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |-> (slotValid == '0));

  // R9
  squash_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |=> ((fetchPc == $past(squashPc)) &&
                     (fetchNextPc == $past(squashPc) + ADDR_W'(4))));

endmodule

bind fetch_group_unit fgu_checker #(
  .ADDR_W (ADDR_W),
  .FETCH_W(FETCH_W),
  .SEQ_W  (SEQ_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lineValid  (lineValid),
  .squashValid(squashValid),
  .squashPc   (squashPc),
  .slotValid  (slotValid),
  .slotSeq    (slotSeq),
  .fetchPc    (fetchPc),
  .fetchNextPc(fetchNextPc)
);

// File: tb/fetch_group_unit_test.sv
`timescale 1ns/1ps
module fetch_group_unit_test;

  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lv = 1'b0;
  logic [511:0]  line = '0;
  logic          sq = 1'b0;
  logic [31:0]   sqPc = '0;
  logic [15:0]   sqSeq = '0;
  logic [3:0]    ctl = '0, tkn = '0, ann = '0;
  logic [127:0]  tgts = '0;
  logic [3:0]    slotValid;
  logic [127:0]  slotInst, slotPc, slotNextPc;
  logic [63:0]   slotSeq;
  logic [31:0]   fetchPc, fetchNextPc, fetchNextNextPc;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // model state
  logic [31:0] mPc = '0;
  logic [31:0] mTgt = '0;
  logic [15:0] mBrSeq = '0;
  logic [15:0] mSeq = '0;
  bit          mPend = 0;
  bit          mBrValid = 0;

  always #10 clk = ~clk;

  fetch_group_unit uut (
    .clk(clk), .rstN(rstN), .lineValid(lv), .lineData(line),
    .squashValid(sq), .squashPc(sqPc), .squashSeq(sqSeq),
    .brIsCtrl(ctl), .brTaken(tkn), .brAnnul(ann), .brTarget(tgts),
    .slotValid(slotValid), .slotInst(slotInst), .slotPc(slotPc),
    .slotNextPc(slotNextPc), .slotSeq(slotSeq), .fetchPc(fetchPc),
    .fetchNextPc(fetchNextPc), .fetchNextNextPc(fetchNextNextPc)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    lv = 0; sq = 0; ctl = '0; tkn = '0; ann = '0; tgts = '0;
  endtask

  task automatic rand_line();
    for (int w = 0; w < 16; w++) line[w*32 +: 32] = $urandom;
  endtask

  // one cycle: called right after a falling edge with inputs already driven
  task automatic do_cycle(input string tag);
    int start, cnt;
    bit run, pend, tr, sk, tseen;
    logic [31:0] tgt, base, nPc;
    logic [15:0] nbs;
    string vt, st;
    start = int'(mPc[5:2]);
    base  = {mPc[31:2], 2'b00};
    run = lv && !sq; pend = mPend; tgt = mTgt; tr = 0; sk = 0; tseen = 0;
    cnt = 0; nbs = mBrSeq;
    #5;
    vt = sq ? "R9" : (!lv ? "R2" : "R4");
    for (int k = 0; k < FW; k++) begin
      bit ev;
      logic [31:0] ePc, eNext;
      string kt;
      ev = 0; ePc = base + 32'(4 * k); eNext = ePc + 32'd4; kt = "R5";
      if (run && (start + k < 16)) begin
        ev = 1; cnt = k + 1;
        if (pend) begin
          pend = 0; tr = 1; eNext = tgt; run = 0; kt = "R6";
        end else if (ctl[k]) begin
          if (tkn[k]) begin
            pend = 1; tgt = tgts[k*32 +: 32]; tseen = 1; nbs = mSeq + 16'(k);
          end else if (ann[k]) begin
            sk = 1; eNext = ePc + 32'd8; run = 0; kt = "R8";
          end
        end
      end
      check(slotValid[k] == ev, vt, $sformatf("slot%0d valid", k),
            32'(slotValid[k]), 32'(ev));
      if (ev) begin
        check(slotInst[k*32 +: 32] == line[(start+k)*32 +: 32], "R3",
              $sformatf("slot%0d inst", k), slotInst[k*32 +: 32], line[(start+k)*32 +: 32]);
        check(slotPc[k*32 +: 32] == ePc, "R3", $sformatf("slot%0d pc", k),
              slotPc[k*32 +: 32], ePc);
        check(slotSeq[k*16 +: 16] == mSeq + 16'(k), "R3", $sformatf("slot%0d seq", k),
              32'(slotSeq[k*16 +: 16]), 32'(mSeq + 16'(k)));
        check(slotNextPc[k*32 +: 32] == eNext, kt, $sformatf("slot%0d next pc", k),
              slotNextPc[k*32 +: 32], eNext);
      end
    end
    @(posedge clk);
    #1;
    if (sq) begin
      mPc = sqPc;
      if (mBrValid && (sqSeq <= mBrSeq)) begin
        mPend = 0; mTgt = '0; mBrValid = 0;
      end
    end else if (lv) begin
      nPc = tr ? tgt : base + 32'(4 * cnt) + (sk ? 32'd4 : 32'd0);
      mPc = nPc; mPend = pend; mTgt = tgt;
      if (tseen) begin mBrSeq = nbs; mBrValid = 1; end
      mSeq = mSeq + 16'(cnt);
    end
    if (tag != "") st = tag;
    else st = sq ? "R9" : (!lv ? "R2" : (tr ? "R6" : (sk ? "R8" : "R4")));
    check(fetchPc == mPc, st, "fetchPc", fetchPc, mPc);
    check(fetchNextPc == mPc + 32'd4, st, "fetchNextPc", fetchNextPc, mPc + 32'd4);
    check(fetchNextNextPc == mPc + 32'd8, st, "fetchNextNextPc", fetchNextNextPc, mPc + 32'd8);
    check(slotSeq[15:0] == mSeq, st, "base seq", 32'(slotSeq[15:0]), 32'(mSeq));
    @(negedge clk);
  endtask

  task automatic squash_to(input logic [31:0] pc, input logic [15:0] s, input string tag);
    clear_in(); sq = 1; sqPc = pc; sqSeq = s;
    do_cycle(tag);
    clear_in();
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rand_line();
    repeat (3) @(negedge clk);
    rstN = 1;
    #5;
    // R1 reset state
    check(fetchPc == 32'h0, "R1", "reset fetchPc", fetchPc, 32'h0);
    check(fetchNextPc == 32'h4, "R1", "reset fetchNextPc", fetchNextPc, 32'h4);
    check(fetchNextNextPc == 32'h8, "R1", "reset fetchNextNextPc", fetchNextNextPc, 32'h8);
    check(slotValid == 4'h0, "R1", "reset slots", 32'(slotValid), 32'h0);
    check(slotSeq[15:0] == 16'h0, "R1", "reset seq", 32'(slotSeq[15:0]), 32'h0);
    @(negedge clk);

    // R2: line not valid, predictor inputs busy
    clear_in(); ctl = 4'hF; tkn = 4'hF; tgts = {4{32'h0000_0800}};
    do_cycle("R2");
    clear_in();

    // R3/R4: plain group from address 0, then group cut by line end
    lv = 1; do_cycle("R4");
    squash_to(32'h1000_0038, 16'h0, "R9");
    lv = 1; do_cycle("R4");

    // R6: taken branch in slot 1, delay slot in slot 2
    squash_to(32'h0000_2000, 16'h0, "R9");
    lv = 1; ctl[1] = 1; tkn[1] = 1; tgts[63:32] = 32'h0000_3000;
    ctl[2] = 1; tkn[2] = 1; tgts[95:64] = 32'h0000_7770; // delay slot flags ignored
    do_cycle("R6");
    clear_in();

    // R7: taken branch in last slot, delay slot in next group
    squash_to(32'h0000_2000, 16'h0, "R9");
    lv = 1; ctl[3] = 1; tkn[3] = 1; tgts[127:96] = 32'h0000_4400;
    do_cycle("R7");
    clear_in(); lv = 1; do_cycle("R7");

    // R8: annulled not-taken branch in slot 0
    squash_to(32'h0000_5008, 16'h0, "R9");
    lv = 1; ctl[0] = 1; ann[0] = 1;
    do_cycle("R8");
    clear_in();

    // R10: squash at the branch number cancels the pending slot
    squash_to(32'h0000_6000, 16'h0, "R9");
    lv = 1; ctl[3] = 1; tkn[3] = 1; tgts[127:96] = 32'h0000_9900;
    do_cycle("R10");
    squash_to(32'h0000_6100, mBrSeq, "R10");
    lv = 1; do_cycle("R10");
    clear_in();

    // R10: squash after the branch keeps the pending slot
    squash_to(32'h0000_6000, 16'h0, "R9");
    lv = 1; ctl[3] = 1; tkn[3] = 1; tgts[127:96] = 32'h0000_9a00;
    do_cycle("R10");
    squash_to(32'h0000_6200, mBrSeq + 16'd1, "R10");
    lv = 1; do_cycle("R10");
    clear_in();

    // R9: squash wins over a valid line
    lv = 1; sq = 1; sqPc = 32'h0000_0a40; sqSeq = 16'hFFFF;
    do_cycle("R9");
    clear_in();

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      clear_in();
      rand_line();
      lv = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 15) == 0) begin
        sq = 1;
        sqPc = {$urandom_range(0, 255) == 0 ? 20'h0 : 20'($urandom), 10'($urandom), 2'b00};
        sqSeq = mBrSeq + 16'($urandom_range(0, 2)) - 16'd1;
      end
      for (int k = 0; k < FW; k++) begin
        ctl[k] = ($urandom_range(0, 3) == 0);
        tkn[k] = $urandom_range(0, 1) == 1;
        ann[k] = $urandom_range(0, 1) == 1;
        tgts[k*32 +: 32] = {20'($urandom), 10'($urandom), 2'b00};
      end
      do_cycle("");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule